// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the memory-mapped front end of an SPI master. A host reaches it over a simple APB-style bus with 32-bit word-aligned accesses. Through that bus it programs the frame configuration, clock divider, slave selects and FIFO thresholds. It moves frames into a transmit FIFO and out of a receive FIFO, and it reads levels and status. A separate serial engine takes the static configuration and the FIFO ports from this block and performs the shifting.

The configuration registers are write-locked while the controller is enabled. Clearing the enable bit flushes both FIFOs. Both threshold registers keep a written value only when it is below the FIFO depth, so software can find the depth by writing rising values and reading back. Overflowing or underflowing accesses leave the FIFO state untouched.

Top module: `spi_regfile`

## Requirements
- R1: After reset, every register reads 0, both levels read 0, `en_o` is 0, and status reads 0x06 (TX not full, TX empty).
- R2: While enable bit 0 is 0, writes to control 0 (0x00), control 1 (0x04), slave enable (0x10) and baud (0x14) are stored and read back. Control 0 drives the frame size [3:0], frame format [5:4], clock phase bit 6, clock polarity bit 7 and transfer mode [9:8] onto the matching outputs.
- R3: While enable (0x08, bit 0) is 1, writes to control 0, control 1, slave enable and baud have no effect.
- R4: The TX threshold (0x18) and the RX threshold (0x1C) store a written 32-bit value only when it is less than DEPTH. Any other write leaves the register unchanged.
- R5: A write to the data register (0x60) pushes one frame into the TX FIFO. `tx_data_o` shows the oldest frame, `tx_pop_i` removes it, and the TX level (0x20) counts the entries.
- R6: A read of the data register returns the oldest RX frame and pops it. `rx_push_i` adds a frame, and the RX level (0x24) counts the entries.
- R7: Status (0x28) packs busy bit 0, TX not full bit 1, TX empty bit 2, RX not empty bit 3, RX full bit 4, transmit error bit 5 and collision bit 6. Busy, transmit error and collision come from the engine inputs.
- R8: A data write with the TX FIFO full is dropped. A data read with the RX FIFO empty returns 0. Neither changes the levels.
- R9: Writing 0 to enable bit 0 empties both FIFOs and clears both levels.
- R10: The interrupt mask (0x2C) stores its low IMW bits, so writing all ones reads back 0x3F with the default IMW of 6.
- R11: Reads of unmapped or unaligned addresses return 0, and status bits 31:7 read 0.
- R12: An `rx_push_i` with the RX FIFO full is dropped and leaves the RX level at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write strobe |
| paddr_i | input | AW | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| en_o | output | 1 | Controller enable |
| dfs_o | output | 4 | Frame size minus one |
| frf_o | output | 2 | Frame format |
| scph_o | output | 1 | Clock phase |
| scpol_o | output | 1 | Clock polarity |
| tmod_o | output | 2 | Transfer mode |
| ctrl1_o | output | 16 | Control 1 value |
| ser_o | output | NSS | Slave enables |
| baud_o | output | 16 | Clock divider |
| txth_o | output | TW | TX threshold |
| rxth_o | output | TW | RX threshold |
| imask_o | output | IMW | Interrupt mask |
| tx_pop_i | input | 1 | Engine takes one TX frame |
| tx_data_o | output | DW | Oldest TX frame |
| tx_empty_o | output | 1 | TX FIFO empty |
| rx_push_i | input | 1 | Engine delivers one RX frame |
| rx_data_i | input | DW | RX frame from the engine |
| busy_i | input | 1 | Engine busy |
| tx_err_i | input | 1 | Transmit error flag |
| dcol_i | input | 1 | Data collision flag |

## Verification
A wrong FIFO pointer or level shows at the next bus read as a level value that does not match the number of accepted pushes and pops, or as frames returned out of order. A lock that leaks shows on the next read-back of the configuration, one access after the write that should have been ignored. A missing flush or a dropped-overflow error shows at once in the level registers and in the status bits.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam logic [7:0] OFS_CTRL0 = 8'h00;
  localparam logic [7:0] OFS_CTRL1 = 8'h04;
  localparam logic [7:0] OFS_EN    = 8'h08;
  localparam logic [7:0] OFS_SER   = 8'h10;
  localparam logic [7:0] OFS_BAUD  = 8'h14;
  localparam logic [7:0] OFS_TXTH  = 8'h18;
  localparam logic [7:0] OFS_RXTH  = 8'h1C;
  localparam logic [7:0] OFS_TXLVL = 8'h20;
  localparam logic [7:0] OFS_RXLVL = 8'h24;
  localparam logic [7:0] OFS_STAT  = 8'h28;
  localparam logic [7:0] OFS_IMASK = 8'h2C;
  localparam logic [7:0] OFS_DATA  = 8'h60;

  typedef struct packed {
    logic dcol;
    logic tx_err;
    logic rx_full;
    logic rx_nempty;
    logic tx_empty;
    logic tx_nfull;
    logic busy;
  } stat_t;
endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign level_o = level_q;
  assign rdata_o = empty_o ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      level_q <= level_q + 1'b1;
      else if (do_pop && !do_push) level_q <= level_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  p_level_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (level_q == LW'(DEPTH)));
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (level_q == '0));
  p_flush_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_rf_cfg.sv
module spi_rf_cfg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             q_o <= '0;
    else if (wr_i && !lock_i) q_o <= wdata_i;
  end

  p_lock_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lock_i) |=> $stable(q_o));
endmodule

// File: rtl/spi_rf_thresh.sv
module spi_rf_thresh #(
  parameter int DEPTH = 8,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [TW-1:0] q_o
);
  logic fits;
  assign fits = (wdata_i < 32'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_o <= '0;
    else if (wr_i && fits)  q_o <= wdata_i[TW-1:0];
  end

  p_reject_big_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !fits) |=> $stable(q_o));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_rf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int NSS   = 4,
  parameter int AW    = 8,
  parameter int IMW   = 6,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [31:0]    pwdata_i,
  output logic [31:0]    prdata_o,
  output logic           en_o,
  output logic [3:0]     dfs_o,
  output logic [1:0]     frf_o,
  output logic           scph_o,
  output logic           scpol_o,
  output logic [1:0]     tmod_o,
  output logic [15:0]    ctrl1_o,
  output logic [NSS-1:0] ser_o,
  output logic [15:0]    baud_o,
  output logic [TW-1:0]  txth_o,
  output logic [TW-1:0]  rxth_o,
  output logic [IMW-1:0] imask_o,
  input  logic           tx_pop_i,
  output logic [DW-1:0]  tx_data_o,
  output logic           tx_empty_o,
  input  logic           rx_push_i,
  input  logic [DW-1:0]  rx_data_i,
  input  logic           busy_i,
  input  logic           tx_err_i,
  input  logic           dcol_i
);
  logic wr, rd;
  logic sel_ctrl0, sel_ctrl1, sel_en, sel_ser, sel_baud, sel_txth, sel_rxth;
  logic sel_txlvl, sel_rxlvl, sel_stat, sel_imask, sel_data;
  logic en_q, flush;
  logic [IMW-1:0] imask_q;
  logic [15:0]    ctrl0_q;
  logic [DW-1:0]  rx_rdata;
  logic [LW-1:0]  tx_lvl, rx_lvl;
  logic           tx_full, rx_full, rx_empty;
  stat_t          stat;

  assign wr = psel_i & penable_i & pwrite_i;
  assign rd = psel_i & penable_i & ~pwrite_i;

  assign sel_ctrl0 = (paddr_i == AW'(OFS_CTRL0));
  assign sel_ctrl1 = (paddr_i == AW'(OFS_CTRL1));
  assign sel_en    = (paddr_i == AW'(OFS_EN));
  assign sel_ser   = (paddr_i == AW'(OFS_SER));
  assign sel_baud  = (paddr_i == AW'(OFS_BAUD));
  assign sel_txth  = (paddr_i == AW'(OFS_TXTH));
  assign sel_rxth  = (paddr_i == AW'(OFS_RXTH));
  assign sel_txlvl = (paddr_i == AW'(OFS_TXLVL));
  assign sel_rxlvl = (paddr_i == AW'(OFS_RXLVL));
  assign sel_stat  = (paddr_i == AW'(OFS_STAT));
  assign sel_imask = (paddr_i == AW'(OFS_IMASK));
  assign sel_data  = (paddr_i == AW'(OFS_DATA));

  assign flush = wr & sel_en & ~pwdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      imask_q <= '0;
    end else begin
      if (wr && sel_en)    en_q    <= pwdata_i[0];
      if (wr && sel_imask) imask_q <= pwdata_i[IMW-1:0];
    end
  end

  spi_rf_cfg #(.W(16)) u_ctrl0 (
    .clk_i, .rst_ni, .wr_i(wr & sel_ctrl0), .lock_i(en_q),
    .wdata_i(pwdata_i[15:0]), .q_o(ctrl0_q));
  spi_rf_cfg #(.W(16)) u_ctrl1 (
    .clk_i, .rst_ni, .wr_i(wr & sel_ctrl1), .lock_i(en_q),
    .wdata_i(pwdata_i[15:0]), .q_o(ctrl1_o));
  spi_rf_cfg #(.W(NSS)) u_ser (
    .clk_i, .rst_ni, .wr_i(wr & sel_ser), .lock_i(en_q),
    .wdata_i(pwdata_i[NSS-1:0]), .q_o(ser_o));
  spi_rf_cfg #(.W(16)) u_baud (
    .clk_i, .rst_ni, .wr_i(wr & sel_baud), .lock_i(en_q),
    .wdata_i(pwdata_i[15:0]), .q_o(baud_o));

  spi_rf_thresh #(.DEPTH(DEPTH)) u_txth (
    .clk_i, .rst_ni, .wr_i(wr & sel_txth), .wdata_i(pwdata_i), .q_o(txth_o));
  spi_rf_thresh #(.DEPTH(DEPTH)) u_rxth (
    .clk_i, .rst_ni, .wr_i(wr & sel_rxth), .wdata_i(pwdata_i), .q_o(rxth_o));

  spi_rf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(wr & sel_data), .wdata_i(pwdata_i[DW-1:0]),
    .pop_i(tx_pop_i), .rdata_o(tx_data_o),
    .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty_o));
  spi_rf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push_i), .wdata_i(rx_data_i),
    .pop_i(rd & sel_data), .rdata_o(rx_rdata),
    .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty));

  assign en_o    = en_q;
  assign imask_o = imask_q;
  assign dfs_o   = ctrl0_q[3:0];
  assign frf_o   = ctrl0_q[5:4];
  assign scph_o  = ctrl0_q[6];
  assign scpol_o = ctrl0_q[7];
  assign tmod_o  = ctrl0_q[9:8];

  always_comb begin
    stat.busy      = busy_i;
    stat.tx_nfull  = ~tx_full;
    stat.tx_empty  = tx_empty_o;
    stat.rx_nempty = ~rx_empty;
    stat.rx_full   = rx_full;
    stat.tx_err    = tx_err_i;
    stat.dcol      = dcol_i;
  end

  always_comb begin
    prdata_o = '0;
    if (sel_ctrl0) prdata_o[15:0]      = ctrl0_q;
    if (sel_ctrl1) prdata_o[15:0]      = ctrl1_o;
    if (sel_en)    prdata_o[0]         = en_q;
    if (sel_ser)   prdata_o[NSS-1:0]   = ser_o;
    if (sel_baud)  prdata_o[15:0]      = baud_o;
    if (sel_txth)  prdata_o[TW-1:0]    = txth_o;
    if (sel_rxth)  prdata_o[TW-1:0]    = rxth_o;
    if (sel_txlvl) prdata_o[LW-1:0]    = tx_lvl;
    if (sel_rxlvl) prdata_o[LW-1:0]    = rx_lvl;
    if (sel_stat)  prdata_o[6:0]       = stat;
    if (sel_imask) prdata_o[IMW-1:0]   = imask_q;
    if (sel_data)  prdata_o[DW-1:0]    = rx_rdata;
  end

  p_flush_levels_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (tx_lvl == '0 && rx_lvl == '0));
  p_empty_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_data && rx_lvl == '0) |-> (prdata_o == '0));
  p_imask_ones_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_imask && pwdata_i == 32'hFFFF_FFFF) |=> (&imask_o));
  p_stat_high_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_stat) |-> (prdata_o[31:7] == '0));
  p_rx_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && rx_push_i && !(rd && sel_data) && !flush) |=> rx_full);
endmodule

// File: tb/spi_regfile_tb.sv
module spi_regfile_tb_top;
  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int NSS   = 4;
  localparam int AW    = 8;
  localparam int IMW   = 6;
  localparam int TW    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic en, scph, scpol, tx_empty;
  logic [3:0] dfs;
  logic [1:0] frf, tmod;
  logic [15:0] ctrl1, baud;
  logic [NSS-1:0] ser;
  logic [TW-1:0] txth, rxth;
  logic [IMW-1:0] imask;
  logic tx_pop = 0, rx_push = 0, busy = 0, tx_err = 0, dcol = 0;
  logic [DW-1:0] tx_data, rx_data = '0;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_regfile #(.DEPTH(DEPTH), .DW(DW), .NSS(NSS), .AW(AW), .IMW(IMW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .en_o(en), .dfs_o(dfs), .frf_o(frf), .scph_o(scph), .scpol_o(scpol),
    .tmod_o(tmod), .ctrl1_o(ctrl1), .ser_o(ser), .baud_o(baud),
    .txth_o(txth), .rxth_o(rxth), .imask_o(imask),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_empty_o(tx_empty),
    .rx_push_i(rx_push), .rx_data_i(rx_data),
    .busy_i(busy), .tx_err_i(tx_err), .dcol_i(dcol));

  // {write, addr, data-or-expected}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h28, 32'h0000_0006},
    {1'b1, 8'h00, 32'h0000_0347},
    {1'b0, 8'h00, 32'h0000_0347},
    {1'b1, 8'h04, 32'h0000_0009},
    {1'b0, 8'h04, 32'h0000_0009},
    {1'b1, 8'h14, 32'h0000_0010},
    {1'b0, 8'h14, 32'h0000_0010},
    {1'b1, 8'h10, 32'h0000_0005},
    {1'b0, 8'h10, 32'h0000_0005},
    {1'b1, 8'h18, 32'h0000_0007},
    {1'b1, 8'h18, 32'h0000_0008},
    {1'b0, 8'h18, 32'h0000_0007},
    {1'b1, 8'h2C, 32'hFFFF_FFFF},
    {1'b0, 8'h2C, 32'h0000_003F},
    {1'b0, 8'h0C, 32'h0000_0000},
    {1'b0, 8'h62, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rx_in(input logic [DW-1:0] d);
    @(negedge clk);
    rx_push = 1; rx_data = d;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic tx_take();
    @(negedge clk);
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(8'h20, r); chk("R1 tx level", r, 0);
    bus_rd(8'h24, r); chk("R1 rx level", r, 0);
    bus_rd(8'h08, r); chk("R1 enable", r, 0);
    chk("R1 en_o", {31'd0, en}, 0);

    // table: R2 R4 R7 R10 R11
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) bus_wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        bus_rd(VEC[i][39:32], r);
        chk($sformatf("vec %0d (R2 R4 R7 R10 R11)", i), r, VEC[i][31:0]);
      end
    end

    // R2 field outputs from 0x347
    chk("R2 fields", {22'd0, tmod, scpol, scph, frf, dfs}, 32'h347);
    chk("R2 ser_o", {28'd0, ser}, 5);

    // R4 RX threshold
    bus_wr(8'h1C, 32'h5);          bus_rd(8'h1C, r); chk("R4 rx thresh", r, 5);
    bus_wr(8'h1C, 32'hFFFF_FFF5);  bus_rd(8'h1C, r); chk("R4 rx thresh big", r, 5);

    // R3 lock while enabled
    bus_wr(8'h08, 1);
    chk("R3 en_o", {31'd0, en}, 1);
    bus_wr(8'h00, 0); bus_wr(8'h04, 32'h55); bus_wr(8'h14, 32'h22); bus_wr(8'h10, 32'hF);
    bus_rd(8'h00, r); chk("R3 ctrl0 locked", r, 32'h347);
    bus_rd(8'h04, r); chk("R3 ctrl1 locked", r, 9);
    bus_rd(8'h14, r); chk("R3 baud locked", r, 32'h10);
    bus_rd(8'h10, r); chk("R3 ser locked", r, 5);

    // R5 TX fill, R8 overflow
    for (int i = 0; i < DEPTH; i++) bus_wr(8'h60, 32'hA000 + i);
    bus_rd(8'h20, r); chk("R5 tx level full", r, 8);
    bus_rd(8'h28, r); chk("R7 status tx full", r, 32'h00);
    bus_wr(8'h60, 32'hBEEF);
    bus_rd(8'h20, r); chk("R8 tx overflow level", r, 8);
    chk("R5 tx head", {16'd0, tx_data}, 32'hA000);
    tx_take();
    chk("R5 tx head after pop", {16'd0, tx_data}, 32'hA001);
    bus_rd(8'h20, r); chk("R5 tx level after pop", r, 7);

    // R6 RX order
    rx_in(16'h1111); rx_in(16'h2222); rx_in(16'h3333);
    bus_rd(8'h24, r); chk("R6 rx level", r, 3);
    bus_rd(8'h28, r); chk("R7 status rx not empty", r, 32'h0A);
    bus_rd(8'h60, r); chk("R6 rx data 0", r, 32'h1111);
    bus_rd(8'h60, r); chk("R6 rx data 1", r, 32'h2222);
    bus_rd(8'h60, r); chk("R6 rx data 2", r, 32'h3333);
    bus_rd(8'h60, r); chk("R8 rx empty read", r, 0);
    bus_rd(8'h24, r); chk("R8 rx empty level", r, 0);

    // R12 RX overflow
    for (int i = 0; i < DEPTH + 1; i++) rx_in(16'h40 + 16'(i));
    bus_rd(8'h24, r); chk("R12 rx level full", r, 8);
    bus_rd(8'h28, r); chk("R7 status rx full", r, 32'h1A);
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(8'h60, r);
      if (i == DEPTH - 1) chk("R12 last rx kept", r, 32'h47);
    end
    bus_rd(8'h24, r); chk("R12 rx drained", r, 0);

    // R9 flush
    rx_in(16'h7777);
    bus_wr(8'h08, 0);
    bus_rd(8'h20, r); chk("R9 tx flushed", r, 0);
    bus_rd(8'h24, r); chk("R9 rx flushed", r, 0);
    chk("R9 tx_empty_o", {31'd0, tx_empty}, 1);
    bus_rd(8'h28, r); chk("R9 status after flush", r, 32'h06);

    // R7 engine flags, R11 upper bits
    @(negedge clk); busy = 1; tx_err = 1; dcol = 1;
    bus_rd(8'h28, r); chk("R7 R11 status flags", r, 32'h67);
    @(negedge clk); busy = 0; tx_err = 0; dcol = 0;

    // R2 writable again after disable
    bus_wr(8'h14, 32'h22);
    bus_rd(8'h14, r); chk("R2 baud after disable", r, 32'h22);

    finish_run();
  end
endmodule